// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block shifts or rotates an 8-bit or 16-bit operand. A request gives the operand, a 3-bit operation code, the incoming carry and overflow flags, a width select, and a count source. The count is either the fixed value one or a register count of up to 255 positions. The unit handles three shifts: left, logical right and arithmetic right. It handles four rotates: plain left, plain right, and left or right through the carry flag. In a rotate through carry, the carry flag acts as one extra bit of the rotating loop.

The work is done one bit position per clock. The unit accepts a request only while it is idle and raises `busy` while it iterates. When the result, the new carry, the new overflow and the modelled instruction cost are valid on the registered outputs, it pulses `done` for one cycle. The cost it reports is 2 clocks for a count of one and 8 plus 4 per position for a register count. The result outputs keep their value until the next completion.

Top module: `shrot_unit`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `busy`, `done`, `res_data`, `res_cf`, `res_of` and `res_cycles` are all zero.
- R2: Operation code 0 shifts left: the vacated LSB gets zero and the bit leaving the MSB becomes CF.
- R3: Code 1 shifts right logically and fills the MSB with zero. Code 2 shifts right arithmetically and keeps the MSB. For both codes, the bit leaving the LSB becomes CF.
- R4: Code 3 rotates left and copies the old MSB into both the LSB and CF. Code 4 rotates right and copies the old LSB into both the MSB and CF.
- R5: Code 5 rotates left through carry and code 6 rotates right through carry. The old CF enters the vacated end and the bit that leaves becomes the new CF, so the loop holds width plus one bits.
- R6: With `req_wide` low, only `req_data[7:0]` takes part, bit 7 is the MSB, and `res_data[15:8]` is zero. With `req_wide` high, all 16 bits take part and bit 15 is the MSB.
- R7: After each pass, OF is the result MSB XOR the new CF for left operations (codes 0, 3, 5). For right operations (codes 1, 2, 4, 6), OF is the result MSB XOR the MSB before that pass. The reported OF comes from the final pass.
- R8: A register count of zero returns the operand, restricted to the selected width, with `req_cf` and `req_of` unchanged.
- R9: `res_cycles` is 2 when `req_var` is low, and 8 + 4 × `req_cnt` when `req_var` is high.
- R10: A request is accepted on a rising edge where `req_valid` is high and `busy` is low. `busy` is then high for n+1 cycles, where n is the number of passes. `done` is high for exactly one cycle, on the cycle in which `busy` falls.
- R11: A request presented while `busy` is high is ignored and leaves the running result unchanged. `res_data` changes only on a cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (0..6) |
| req_wide | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| req_var | input | 1 | 1 = count from req_cnt, 0 = count of one |
| req_cnt | input | 8 | Register count |
| req_data | input | 16 | Operand |
| req_cf | input | 1 | Incoming carry flag |
| req_of | input | 1 | Incoming overflow flag |
| busy | output | 1 | Unit is iterating |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 16 | Result |
| res_cf | output | 1 | Resulting carry flag |
| res_of | output | 1 | Resulting overflow flag |
| res_cycles | output | 11 | Modelled clock cost of the operation |

## Verification
The checker assumes that `req_op` never carries the unused code 7 and that the request fields are meaningful only on the accepting edge. It captures those fields at that edge and checks the completion against them. The stimulus keeps random codes in the range 0 to 6 and random counts below 20 so each run stays short. Directed cases cover a zero count, counts beyond the operand width, and a request driven while busy.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6
  } op_e;

  localparam int COST_ONE  = 2;
  localparam int COST_BASE = 8;
  localparam int COST_STEP = 4;
endpackage

// File: rtl/shrot_step.sv
module shrot_step
  import shrot_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] d_i,
  input  logic         cf_i,
  input  op_e          op_i,
  input  logic         wide_i,
  output logic [W-1:0] d_o,
  output logic         cf_o,
  output logic         of_o
);
  localparam int H = W / 2;
  localparam logic [W-1:0] TOP_W  = W'(1) << (W - 1);
  localparam logic [W-1:0] TOP_B  = W'(1) << (H - 1);
  localparam logic [W-1:0] MASK_B = {{H{1'b0}}, {H{1'b1}}};

  logic [W-1:0] top, mask, d;
  logic         msb, lsb, is_left, in_bit, fill;

  always_comb begin
    top  = wide_i ? TOP_W : TOP_B;
    mask = wide_i ? '1 : MASK_B;
    d    = d_i & mask;
    msb  = |(d & top);
    lsb  = d[0];
    is_left = 1'b1;
    in_bit  = 1'b0;
    fill    = 1'b0;
    case (op_i)
      OP_ROL:  in_bit = msb;
      OP_RCL:  in_bit = cf_i;
      OP_SHR:  is_left = 1'b0;
      OP_SAR:  begin is_left = 1'b0; fill = msb;  end
      OP_ROR:  begin is_left = 1'b0; fill = lsb;  end
      OP_RCR:  begin is_left = 1'b0; fill = cf_i; end
      default: in_bit = 1'b0;
    endcase
    if (is_left) begin
      d_o  = ((d << 1) | {{(W-1){1'b0}}, in_bit}) & mask;
      cf_o = msb;
      of_o = (|(d_o & top)) ^ msb;
    end else begin
      d_o  = (d >> 1) | (fill ? top : '0);
      cf_o = lsb;
      of_o = (|(d_o & top)) ^ msb;
    end
  end
endmodule

// File: rtl/shrot_cost.sv
module shrot_cost
  import shrot_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CYC_W = 11
) (
  input  logic             var_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CYC_W-1:0] cyc_o
);
  always_comb begin
    if (var_i) cyc_o = CYC_W'(COST_BASE) + CYC_W'(COST_STEP) * CYC_W'(cnt_i);
    else       cyc_o = CYC_W'(COST_ONE);
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int CNT_W  = 8,
  localparam int CYC_W  = $clog2(COST_BASE + COST_STEP * ((1 << CNT_W) - 1) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic              req_wide,
  input  logic              req_var,
  input  logic [CNT_W-1:0]  req_cnt,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_cf,
  input  logic              req_of,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] res_data,
  output logic              res_cf,
  output logic              res_of,
  output logic [CYC_W-1:0]  res_cycles
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] LOW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  op_e               op_q;
  logic              wide_q;
  logic [DATA_W-1:0] w_data, s_data;
  logic              w_cf, w_of, s_cf, s_of;
  logic [CNT_W-1:0]  left_q;
  logic [CYC_W-1:0]  cost, cyc_q;

  shrot_step #(.W(DATA_W)) u_step (
    .d_i(w_data), .cf_i(w_cf), .op_i(op_q), .wide_i(wide_q),
    .d_o(s_data), .cf_o(s_cf), .of_o(s_of)
  );

  shrot_cost #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_cost (
    .var_i(req_var), .cnt_i(req_cnt), .cyc_o(cost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      res_data   <= '0;
      res_cf     <= 1'b0;
      res_of     <= 1'b0;
      res_cycles <= '0;
      op_q       <= OP_SHL;
      wide_q     <= 1'b0;
      w_data     <= '0;
      w_cf       <= 1'b0;
      w_of       <= 1'b0;
      left_q     <= '0;
      cyc_q      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          op_q   <= op_e'(req_op);
          wide_q <= req_wide;
          w_data <= req_data;
          w_cf   <= req_cf;
          w_of   <= req_of;
          left_q <= req_var ? req_cnt : CNT_W'(1);
          cyc_q  <= cost;
        end
      end else if (left_q == '0) begin
        busy       <= 1'b0;
        done       <= 1'b1;
        res_data   <= wide_q ? w_data : (w_data & LOW_MASK);
        res_cf     <= w_cf;
        res_of     <= w_of;
        res_cycles <= cyc_q;
      end else begin
        w_data <= s_data;
        w_cf   <= s_cf;
        w_of   <= s_of;
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk
  import shrot_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int CNT_W  = 8,
  localparam int CYC_W  = $clog2(COST_BASE + COST_STEP * ((1 << CNT_W) - 1) + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_wide,
  input logic              req_var,
  input logic [CNT_W-1:0]  req_cnt,
  input logic [DATA_W-1:0] req_data,
  input logic              req_cf,
  input logic              req_of,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] res_data,
  input logic              res_cf,
  input logic              res_of,
  input logic [CYC_W-1:0]  res_cycles
);
  localparam int HALF_W = DATA_W / 2;

  logic              cap_wide, cap_var, cap_cf, cap_of;
  logic [CNT_W-1:0]  cap_cnt;
  logic [DATA_W-1:0] cap_data;
  logic [CYC_W-1:0]  exp_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_wide <= 1'b0; cap_var <= 1'b0; cap_cf <= 1'b0; cap_of <= 1'b0;
      cap_cnt  <= '0;   cap_data <= '0;
    end else if (req_valid && !busy) begin
      cap_wide <= req_wide;
      cap_var  <= req_var;
      cap_cnt  <= req_cnt;
      cap_cf   <= req_cf;
      cap_of   <= req_of;
      cap_data <= req_wide ? req_data : {{HALF_W{1'b0}}, req_data[HALF_W-1:0]};
    end
  end

  assign exp_cyc = cap_var ? CYC_W'(COST_BASE + COST_STEP * int'(cap_cnt)) : CYC_W'(COST_ONE);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst) (req_valid && !busy) |=> busy);
  // R9
  cost_value_chk: assert property (@(posedge clk) disable iff (rst) done |-> res_cycles == exp_cyc);
  // R6
  byte_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !cap_wide) |-> res_data[DATA_W-1:HALF_W] == '0);
  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cap_var && cap_cnt == '0) |-> (res_data == cap_data && res_cf == cap_cf && res_of == cap_of));
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(res_data));
endmodule

bind shrot_unit shrot_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_wide(req_wide), .req_var(req_var),
  .req_cnt(req_cnt), .req_data(req_data), .req_cf(req_cf), .req_of(req_of),
  .busy(busy), .done(done), .res_data(res_data), .res_cf(res_cf), .res_of(res_of),
  .res_cycles(res_cycles)
);

// File: tb/test_shrot_unit.sv
module test_shrot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = '0;
  logic        req_wide = 1'b0, req_var = 1'b0, req_cf = 1'b0, req_of = 1'b0;
  logic [7:0]  req_cnt = '0;
  logic [15:0] req_data = '0;
  logic        busy, done, res_cf, res_of;
  logic [15:0] res_data;
  logic [10:0] res_cycles;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shrot_unit i_shrot_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic model(input logic [2:0] op, input logic w, input logic v, input logic [7:0] cnt,
                       input logic [15:0] data, input logic cf, input logic of,
                       output logic [15:0] r, output logic rc, output logic ro, output int cyc);
    int mi = w ? 15 : 7;
    logic [15:0] mk = w ? 16'hFFFF : 16'h00FF;
    int n = v ? int'(cnt) : 1;
    logic old, nb;
    r = data & mk; rc = cf; ro = of;
    for (int i = 0; i < n; i++) begin
      old = r[mi];
      if (op == 3'd0 || op == 3'd3 || op == 3'd5) begin
        nb = (op == 3'd0) ? 1'b0 : (op == 3'd3) ? old : rc;
        r = ((r << 1) | {15'd0, nb}) & mk;
        rc = old;
        ro = r[mi] ^ rc;
      end else begin
        nb = (op == 3'd1) ? 1'b0 : (op == 3'd2) ? old : (op == 3'd4) ? r[0] : rc;
        rc = r[0];
        r = r >> 1;
        r[mi] = nb;
        ro = r[mi] ^ old;
      end
    end
    cyc = v ? 8 + 4 * int'(cnt) : 2;
  endtask

  task automatic run(input logic [2:0] op, input logic w, input logic v, input logic [7:0] cnt,
                     input logic [15:0] data, input logic cf, input logic of, input bit poke);
    logic [15:0] er; logic ec, eo; int ecyc; int k; int n;
    logic [15:0] prev;
    model(op, w, v, cnt, data, cf, of, er, ec, eo, ecyc);
    n = v ? int'(cnt) : 1;
    @(negedge clk);
    prev = res_data;
    req_valid = 1'b1; req_op = op; req_wide = w; req_var = v;
    req_cnt = cnt; req_data = data; req_cf = cf; req_of = of;
    @(negedge clk);
    k = 1;
    while (!done && k < 2000) begin
      if (poke && k == 1) begin
        req_valid = 1'b1; req_op = 3'd0; req_var = 1'b0; req_data = ~data; req_cf = ~cf;
        check("R11", {31'd0, busy}, 32'd1);
      end else begin
        req_valid = 1'b0;
      end
      check("R11", {16'd0, res_data}, {16'd0, prev});
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    check(op_tag(op), {16'd0, res_data}, {16'd0, er});
    check(op_tag(op), {31'd0, res_cf}, {31'd0, ec});
    check("R7", {31'd0, res_of}, {31'd0, eo});
    check("R9", {21'd0, res_cycles}, ecyc);
    check("R10", k, n + 2);
    check("R10", {31'd0, busy}, 32'd0);
    @(negedge clk);
    check("R10", {31'd0, done}, 32'd0);
  endtask

  initial begin
    int cnt_bound = 200000;
    for (int c = 0; c < cnt_bound && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", {31'd0, busy}, 0);
    check("R1", {31'd0, done}, 0);
    check("R1", {16'd0, res_data}, 0);
    check("R1", {21'd0, res_cycles}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {30'd0, res_cf, res_of}, 0);
    // R2 directed: wide left by one
    run(3'd0, 1'b1, 1'b0, 8'd0, 16'h8001, 1'b0, 1'b0, 1'b0);
    // R3 directed: byte arithmetic right, upper operand bits ignored (R6)
    run(3'd2, 1'b0, 1'b0, 8'd0, 16'hAB81, 1'b0, 1'b1, 1'b0);
    run(3'd1, 1'b1, 1'b1, 8'd4, 16'hF00F, 1'b0, 1'b0, 1'b0);
    // R4 directed, with a request while busy (R11)
    run(3'd4, 1'b1, 1'b1, 8'd3, 16'h0005, 1'b0, 1'b0, 1'b1);
    run(3'd3, 1'b0, 1'b1, 8'd8, 16'h12C3, 1'b1, 1'b0, 1'b0);
    // R5 directed: nine passes through a byte plus carry returns the operand
    run(3'd5, 1'b0, 1'b1, 8'd9, 16'h005A, 1'b1, 1'b0, 1'b0);
    run(3'd6, 1'b1, 1'b1, 8'd17, 16'hBEEF, 1'b0, 1'b0, 1'b0);
    // R8 zero count
    run(3'd2, 1'b0, 1'b1, 8'd0, 16'hFF96, 1'b1, 1'b1, 1'b1);
    // R6 count beyond byte width
    run(3'd0, 1'b0, 1'b1, 8'd17, 16'h00FF, 1'b0, 1'b0, 1'b0);
    // R9 largest count
    run(3'd3, 1'b1, 1'b1, 8'd255, 16'h1234, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 60; i++) begin
      logic [2:0] op = 3'($urandom % 7);
      logic v = 1'($urandom);
      run(op, 1'($urandom), v, 8'($urandom % 20), 16'($urandom), 1'($urandom), 1'($urandom),
          (i % 5) == 0);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule